// File: doc/BRIEF.md
# Serial Management Slave Register Port

This block is the management end of a PHY. It listens to a two-wire management bus, a clock from the station manager and one shared data line, and gives the manager read and write access to a small file of 16-bit registers. The block is clocked by the management clock itself and samples the data line on each rising edge. It drives the line through a separate output enable, so an external pull-up or pad holds the line high whenever nobody drives it.

A frame is accepted only after a preamble of at least 32 ones. It carries a start field, a read-select and write-select pair, the 5-bit device address, the 5-bit register address, a two-bit turnaround and 16 data bits. The register file holds a control word, a link status bit that latches low, four event bits that latch high, a mask and a configuration bit. The control word has a self-clearing soft-reset bit and a negotiation-restart bit that stays set until the PHY reports that the restart has begun. When the configuration bit allows it, the block announces a newly pending unmasked event by pulling the line low for one clock while the bus is idle.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A frame is decoded only after at least 32 consecutive ones have been sampled. A frame whose preamble holds 31 ones has no effect, and a frame whose preamble holds 40 ones is accepted.
- R2: The start field must be 0 then 1. The two operation bits are read-select and then write-select, so 10 is a read and 01 is a write. A bad start field, or the operation codes 00 or 11, abandons the frame with no effect.
- R3: A frame whose device address differs from `phy_addr` never drives the line. It writes nothing and clears no latched bit.
- R4: In a read, the line is released during the first turnaround bit and driven to 0 during the second. The 16 data bits then follow MSB first, and the line is released again after bit 0.
- R5: A write stores 16 bits at the register address. The register map is: 0 control, 1 status, 2 events, 3 mask, 4 configuration. Reads of any other address return 0, and writes to them are dropped. Control bits other than 15 and 9 are plain read/write and appear on `ctrl_word`.
- R6: Writing 1 to control bit 15 raises `soft_reset` for exactly one clock. The bit then reads 0, and the control, mask and configuration registers return to their reset values.
- R7: Writing 1 to control bit 9 sets it. It reads 1 until `aneg_begin` is sampled high. Writing 0 to it has no effect.
- R8: Event register bits 0 to 3 latch high on `status_evt[0..3]` (link fail, sync loss, speed change, duplex change). A completed read of the register clears the bits it returned, except those whose event is still active.
- R9: Status bit 2 latches low. It resets to 0 and drops whenever `link_ok` is low. A completed read of the status register loads the current `link_ok`.
- R10: The mask register resets to 0x000F. An event bit is pending only when its latched bit is 1 and its mask bit is 0.
- R11: While configuration bit 0 is 1, a pending condition that newly appears gives a single one-clock low pulse on the line while no frame is in progress. While the bit is 0, no pulse is given.
- R12: After reset the line is released, `soft_reset` is low and `ctrl_word` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_addr | input | 5 | Device address this slave answers to |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_out | output | 1 | Level driven onto the data line while enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| status_evt | input | 4 | Event sources: link fail, sync loss, speed change, duplex change |
| link_ok | input | 1 | Current link state for the latch-low status bit |
| aneg_begin | input | 1 | High when the negotiation restart has begun |
| ctrl_word | output | 16 | Current control register |
| soft_reset | output | 1 | One-clock pulse from the self-clearing soft-reset bit |

## Verification
The hardest behaviour to reach is the interaction between latched events, the mask and the idle-time interrupt pulse. The pulse must appear once for an unmasked event and never for a masked one. It must not be mistaken for a start bit, and a later frame must still be decoded after it. The stimulus first programs the mask and enable through ordinary write frames, then fires single-cycle events with the host released, counts low pulses outside frames, and finally reads the event register to confirm what was latched. A second hard case is an event held active across a completed read. Here the event is asserted before a read frame and held through two reads, which shows that the read-clear leaves active bits set.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int NUM_EVT = 4;

    localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] RA_EVT  = 5'd2;
    localparam logic [ADDR_W-1:0] RA_MASK = 5'd3;
    localparam logic [ADDR_W-1:0] RA_CFG  = 5'd4;

    localparam int CTRL_SRST  = 15;
    localparam int CTRL_ANEG  = 9;
    localparam int STAT_LINK  = 2;
    localparam int CFG_IRQ_EN = 0;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PRE,
        FS_ST,
        FS_OP,
        FS_PHY,
        FS_REG,
        FS_TA,
        FS_DATA
    } fsm_state_e;

endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              irq_pulse,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_start,
    output logic              rd_done,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_oe,
    output logic              frame_out,
    output logic              bus_idle
);

    localparam int CNT_W = ($clog2(PRE_LEN + 1) > 5) ? $clog2(PRE_LEN + 1) : 5;
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        fsm_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              op_rd;
        logic              match;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] shift;
        logic              oe;
        logic              dout;
    } fsm_regs_t;

    fsm_regs_t q, d;

    logic [ADDR_W-1:0] addr_now;
    assign addr_now = {q.addr[ADDR_W-2:0], mdio_in};

    always_comb begin
        d         = q;
        d.oe      = 1'b0;
        d.dout    = 1'b1;
        rd_start  = 1'b0;
        rd_done   = 1'b0;
        wr_en     = 1'b0;
        acc_addr  = q.addr;
        wr_data   = {q.shift[DATA_W-2:0], mdio_in};

        case (q.st)
            FS_IDLE: begin
                if (!mdio_in) begin
                    d.cnt = '0;
                end else if (q.cnt == PRE_LAST) begin
                    d.st  = FS_PRE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            FS_PRE: begin
                if (!mdio_in) d.st = FS_ST;
            end
            FS_ST: begin
                d.cnt = '0;
                d.st  = mdio_in ? FS_OP : FS_IDLE;
            end
            FS_OP: begin
                if (q.cnt == '0) begin
                    d.op_rd = mdio_in;
                    d.cnt   = q.cnt + 1'b1;
                end else begin
                    d.cnt = '0;
                    d.st  = (q.op_rd ^ mdio_in) ? FS_PHY : FS_IDLE;
                end
            end
            FS_PHY: begin
                d.addr = addr_now;
                if (q.cnt == ADDR_LAST) begin
                    d.match = (addr_now == phy_addr);
                    d.st    = FS_REG;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            FS_REG: begin
                d.addr   = addr_now;
                acc_addr = addr_now;
                if (q.cnt == ADDR_LAST) begin
                    d.st  = FS_TA;
                    d.cnt = '0;
                    if (q.match && q.op_rd) begin
                        rd_start = 1'b1;
                        d.shift  = rd_data;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            FS_TA: begin
                if (q.cnt == '0) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.match && q.op_rd) begin
                        d.oe   = 1'b1;
                        d.dout = 1'b0;
                    end
                end else begin
                    d.st  = FS_DATA;
                    d.cnt = '0;
                    if (q.match && q.op_rd) begin
                        d.oe    = 1'b1;
                        d.dout  = q.shift[DATA_W-1];
                        d.shift = {q.shift[DATA_W-2:0], 1'b0};
                    end
                end
            end
            FS_DATA: begin
                if (q.op_rd) begin
                    if (q.cnt == DATA_LAST) begin
                        d.st    = FS_IDLE;
                        d.cnt   = '0;
                        rd_done = q.match;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.match) begin
                            d.oe    = 1'b1;
                            d.dout  = q.shift[DATA_W-1];
                            d.shift = {q.shift[DATA_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    d.shift = {q.shift[DATA_W-2:0], mdio_in};
                    if (q.cnt == DATA_LAST) begin
                        wr_en = q.match;
                        d.st  = FS_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.st  = FS_IDLE;
                d.cnt = '0;
            end
        endcase

        // An idle-time interrupt pulse is our own low level: never treat it as a start bit.
        if (irq_pulse) begin
            d.st  = FS_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= FS_IDLE;
            q.cnt   <= '0;
            q.op_rd <= 1'b0;
            q.match <= 1'b0;
            q.addr  <= '0;
            q.shift <= '0;
            q.oe    <= 1'b0;
            q.dout  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frame_oe  = q.oe;
    assign frame_out = q.dout;
    assign bus_idle  = (q.st == FS_IDLE) || (q.st == FS_PRE);

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter logic [DATA_W-1:0]  CTRL_RST = 16'h0000,
    parameter logic [NUM_EVT-1:0] MASK_RST = 4'hF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               rd_start,
    input  logic               rd_done,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_EVT-1:0] status_evt,
    input  logic               link_ok,
    input  logic               aneg_begin,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  ctrl_word,
    output logic               soft_reset,
    output logic               irq_en,
    output logic               pending,
    output logic [NUM_EVT-1:0] evt_lat,
    output logic               link_lat
);

    localparam logic [DATA_W-1:0] ANEG_M = DATA_W'(1) << CTRL_ANEG;

    typedef struct packed {
        logic [DATA_W-1:0]  ctrl;
        logic [NUM_EVT-1:0] evt;
        logic [NUM_EVT-1:0] snap;
        logic               link;
        logic [NUM_EVT-1:0] mask;
        logic               irq_en;
    } rf_regs_t;

    rf_regs_t q, d;

    always_comb begin
        rd_data = '0;
        case (acc_addr)
            RA_CTRL: rd_data = q.ctrl;
            RA_STAT: rd_data[STAT_LINK] = q.link;
            RA_EVT:  rd_data[NUM_EVT-1:0] = q.evt;
            RA_MASK: rd_data[NUM_EVT-1:0] = q.mask;
            RA_CFG:  rd_data[CFG_IRQ_EN] = q.irq_en;
            default: rd_data = '0;
        endcase
    end

    always_comb begin
        logic [NUM_EVT-1:0] clr;
        d = q;
        d.ctrl[CTRL_SRST] = 1'b0;

        if (rd_start && acc_addr == RA_EVT) d.snap = q.evt;
        clr   = (rd_done && acc_addr == RA_EVT) ? q.snap : '0;
        d.evt = (q.evt & ~clr) | status_evt;

        if (rd_done && acc_addr == RA_STAT) d.link = link_ok;
        else                                d.link = q.link & link_ok;

        if (wr_en) begin
            case (acc_addr)
                RA_CTRL: d.ctrl   = (wr_data & ~ANEG_M) | ((q.ctrl | wr_data) & ANEG_M);
                RA_MASK: d.mask   = wr_data[NUM_EVT-1:0];
                RA_CFG:  d.irq_en = wr_data[CFG_IRQ_EN];
                default: ;
            endcase
        end

        if (aneg_begin) d.ctrl[CTRL_ANEG] = 1'b0;

        if (q.ctrl[CTRL_SRST]) begin
            d.ctrl   = CTRL_RST;
            d.mask   = MASK_RST;
            d.irq_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl   <= CTRL_RST;
            q.evt    <= '0;
            q.snap   <= '0;
            q.link   <= 1'b0;
            q.mask   <= MASK_RST;
            q.irq_en <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_word  = q.ctrl;
    assign soft_reset = q.ctrl[CTRL_SRST];
    assign irq_en     = q.irq_en;
    assign pending    = |(q.evt & ~q.mask);
    assign evt_lat    = q.evt;
    assign link_lat   = q.link;

endmodule

// File: rtl/mgmt_irq_pulse.sv
module mgmt_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic irq_en,
    input  logic bus_idle,
    output logic irq_pulse
);

    typedef struct packed {
        logic pend_prev;
        logic req;
        logic pulse;
    } irq_regs_t;

    irq_regs_t q, d;

    always_comb begin
        d           = q;
        d.pend_prev = pending;
        d.req       = q.req | (pending & ~q.pend_prev);
        d.pulse     = 1'b0;
        if (!irq_en) begin
            d.req = 1'b0;
        end else if (q.req && bus_idle && !q.pulse) begin
            d.pulse = 1'b1;
            d.req   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend_prev <= 1'b0;
            q.req       <= 1'b0;
            q.pulse     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign irq_pulse = q.pulse;

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int                 PRE_LEN  = 32,
    parameter logic [DATA_W-1:0]  CTRL_RST = 16'h0000,
    parameter logic [NUM_EVT-1:0] MASK_RST = 4'hF
) (
    input  logic               mdc,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  phy_addr,
    input  logic               mdio_in,
    output logic               mdio_out,
    output logic               mdio_oe,
    input  logic [NUM_EVT-1:0] status_evt,
    input  logic               link_ok,
    input  logic               aneg_begin,
    output logic [DATA_W-1:0]  ctrl_word,
    output logic               soft_reset
);

    logic [ADDR_W-1:0]  acc_addr;
    logic               rd_start;
    logic               rd_done;
    logic               wr_en;
    logic [DATA_W-1:0]  wr_data;
    logic [DATA_W-1:0]  rd_data;
    logic               frame_oe;
    logic               frame_out;
    logic               bus_idle;
    logic               irq_en;
    logic               pending;
    logic               irq_pulse;
    logic [NUM_EVT-1:0] evt_lat;
    logic               link_lat;

    mgmt_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_in   (mdio_in),
        .phy_addr  (phy_addr),
        .irq_pulse (irq_pulse),
        .rd_data   (rd_data),
        .acc_addr  (acc_addr),
        .rd_start  (rd_start),
        .rd_done   (rd_done),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .frame_oe  (frame_oe),
        .frame_out (frame_out),
        .bus_idle  (bus_idle)
    );

    mgmt_regfile #(.CTRL_RST(CTRL_RST), .MASK_RST(MASK_RST)) u_rf (
        .clk        (mdc),
        .rst_n      (rst_n),
        .acc_addr   (acc_addr),
        .rd_start   (rd_start),
        .rd_done    (rd_done),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .status_evt (status_evt),
        .link_ok    (link_ok),
        .aneg_begin (aneg_begin),
        .rd_data    (rd_data),
        .ctrl_word  (ctrl_word),
        .soft_reset (soft_reset),
        .irq_en     (irq_en),
        .pending    (pending),
        .evt_lat    (evt_lat),
        .link_lat   (link_lat)
    );

    mgmt_irq_pulse u_irq (
        .clk       (mdc),
        .rst_n     (rst_n),
        .pending   (pending),
        .irq_en    (irq_en),
        .bus_idle  (bus_idle),
        .irq_pulse (irq_pulse)
    );

    assign mdio_oe  = frame_oe | irq_pulse;
    assign mdio_out = irq_pulse ? 1'b0 : frame_out;

endmodule

// File: rtl/mgmt_slave_chk.sv
module mgmt_slave_chk #(
    parameter int NUM_EVT = 4
) (
    input logic               mdc,
    input logic               rst_n,
    input logic               mdio_oe,
    input logic               mdio_out,
    input logic               soft_reset,
    input logic [15:0]        ctrl_word,
    input logic               aneg_begin,
    input logic [NUM_EVT-1:0] status_evt,
    input logic [NUM_EVT-1:0] evt_lat,
    input logic               link_ok,
    input logic               link_lat,
    input logic               irq_en,
    input logic               irq_pulse
);

    AST_SRST_ONE_CYCLE: assert property (@(posedge mdc) disable iff (!rst_n)
        soft_reset |=> !soft_reset); // R6

    AST_DRIVE_STARTS_LOW: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out); // R4

    AST_ANEG_HOLDS: assert property (@(posedge mdc) disable iff (!rst_n)
        (ctrl_word[9] && !aneg_begin && !soft_reset) |=> ctrl_word[9]); // R7

    AST_EVT_LATCHES: assert property (@(posedge mdc) disable iff (!rst_n)
        (status_evt != '0) |=> ((evt_lat & $past(status_evt)) == $past(status_evt))); // R8

    AST_LINK_DROPS: assert property (@(posedge mdc) disable iff (!rst_n)
        !link_ok |=> !link_lat); // R9

    AST_PULSE_SINGLE: assert property (@(posedge mdc) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R11

    AST_PULSE_NEEDS_EN: assert property (@(posedge mdc) disable iff (!rst_n)
        !irq_en |=> !irq_pulse); // R11

endmodule

bind mgmt_serial_slave mgmt_slave_chk #(.NUM_EVT(mgmt_pkg::NUM_EVT)) u_chk (
    .mdc        (mdc),
    .rst_n      (rst_n),
    .mdio_oe    (mdio_oe),
    .mdio_out   (mdio_out),
    .soft_reset (soft_reset),
    .ctrl_word  (ctrl_word),
    .aneg_begin (aneg_begin),
    .status_evt (status_evt),
    .evt_lat    (evt_lat),
    .link_ok    (link_ok),
    .link_lat   (link_lat),
    .irq_en     (irq_en),
    .irq_pulse  (irq_pulse)
);

// File: tb/tb_mgmt_serial_slave.sv
`timescale 1ns/1ps
module tb_mgmt_serial_slave;

    localparam logic [4:0] MY_PHY = 5'h05;
    localparam logic [4:0] OTHER  = 5'h0A;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_oe = 1'b0;
    logic        host_bit = 1'b1;
    logic [3:0]  status_evt = '0;
    logic        link_ok = 1'b1;
    logic        aneg_begin = 1'b0;
    logic        dut_out, dut_oe, soft_reset;
    logic [15:0] ctrl_word;
    wire         line = dut_oe ? dut_out : (host_oe ? host_bit : 1'b1);

    int checks = 0;
    int fails  = 0;
    int pulse_cnt = 0;
    int srst_hi = 0;
    bit busy = 1'b0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] cap_word;
    event        cap_ev;

    always #5 mdc = ~mdc;

    mgmt_serial_slave dut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(MY_PHY), .mdio_in(line),
        .mdio_out(dut_out), .mdio_oe(dut_oe), .status_evt(status_evt),
        .link_ok(link_ok), .aneg_begin(aneg_begin),
        .ctrl_word(ctrl_word), .soft_reset(soft_reset)
    );

    always @(negedge mdc) begin
        if (!busy && dut_oe && !dut_out) pulse_cnt++;
        if (soft_reset) srst_hi++;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    endtask

    // Monitor: pops the expected word and compares it when a read completes.
    initial begin
        forever begin
            @(cap_ev);
            check(tag_q.pop_front(), cap_word, exp_q.pop_front());
        end
    end

    task automatic send_bit(input logic b);
        @(negedge mdc);
        host_oe  = 1'b1;
        host_bit = b;
    endtask

    task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                             input bit rd, output logic [15:0] got, output logic [2:0] ta,
                             output bit drove);
        busy = 1'b1; drove = 1'b0; got = '0; ta = 3'b000;
        send_bit(1'b0); send_bit(1'b0);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(st[1]); send_bit(st[0]); send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        if (!rd) begin
            send_bit(1'b1); send_bit(1'b0);
            for (int i = 15; i >= 0; i--) send_bit(wd[i]);
            @(negedge mdc); host_oe = 1'b0;
        end else begin
            for (int k = 0; k < 19; k++) begin
                @(negedge mdc); host_oe = 1'b0; #1;
                if (dut_oe) drove = 1'b1;
                if (k == 0) ta[2] = line;
                else if (k == 1) ta[1] = line;
                else if (k < 18) got[17-k] = line;
                else ta[0] = line;
            end
        end
        repeat (2) @(negedge mdc);
        busy = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] g; logic [2:0] t; bit dr;
        run_frame(32, 2'b01, 2'b01, MY_PHY, ra, wd, 1'b0, g, t, dr);
    endtask

    task automatic do_read(input logic [4:0] ra, input logic [15:0] exp, input string tag);
        logic [15:0] g; logic [2:0] t; bit dr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        run_frame(32, 2'b01, 2'b10, MY_PHY, ra, 16'h0, 1'b1, g, t, dr);
        check({tag, " R4 turnaround"}, {13'h0, t}, 16'h0005);
        cap_word = g;
        ->cap_ev;
        @(negedge mdc);
    endtask

    task automatic evt_pulse(input logic [3:0] m);
        @(negedge mdc); status_evt = m;
        @(negedge mdc); status_evt = '0;
    endtask

    task automatic aneg_pulse();
        @(negedge mdc); aneg_begin = 1'b1;
        @(negedge mdc); aneg_begin = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] g; logic [2:0] t; bit dr;
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        check("R12 oe after reset", {15'h0, dut_oe}, 16'h0);
        check("R12 soft_reset after reset", {15'h0, soft_reset}, 16'h0);
        check("R12 ctrl_word after reset", ctrl_word, 16'h0000);
        do_read(5'd0, 16'h0000, "R12 ctrl default");
        do_read(5'd3, 16'h000F, "R10 mask default");
        do_read(5'd4, 16'h0000, "R12 cfg default");
        do_read(5'd2, 16'h0000, "R8 evt default");
        do_read(5'd1, 16'h0000, "R9 link latched low at reset");
        do_read(5'd1, 16'h0004, "R9 link reload after read");
        do_read(5'd7, 16'h0000, "R5 unmapped read");

        // Control register and negotiation restart
        do_write(5'd0, 16'h1234);
        check("R5 ctrl_word port", ctrl_word, 16'h1234);
        do_read(5'd0, 16'h1234, "R5 ctrl readback");
        aneg_pulse();
        do_read(5'd0, 16'h1034, "R7 restart cleared by begin");
        do_write(5'd0, 16'h0200);
        do_write(5'd0, 16'h0000);
        do_read(5'd0, 16'h0200, "R7 write 0 ignored");
        aneg_pulse();
        do_read(5'd0, 16'h0000, "R7 cleared after begin");

        // Preamble length
        run_frame(31, 2'b01, 2'b01, MY_PHY, 5'd0, 16'h0055, 1'b0, g, t, dr);
        do_read(5'd0, 16'h0000, "R1 31 ones ignored");
        run_frame(40, 2'b01, 2'b01, MY_PHY, 5'd0, 16'h0055, 1'b0, g, t, dr);
        do_read(5'd0, 16'h0055, "R1 40 ones accepted");
        do_write(5'd0, 16'h00AA);
        do_read(5'd0, 16'h00AA, "R1 32 ones accepted");

        // Start and operation codes
        run_frame(32, 2'b01, 2'b11, MY_PHY, 5'd0, 16'h0F0F, 1'b0, g, t, dr);
        do_read(5'd0, 16'h00AA, "R2 op 11 ignored");
        run_frame(32, 2'b01, 2'b00, MY_PHY, 5'd0, 16'h0F0F, 1'b0, g, t, dr);
        do_read(5'd0, 16'h00AA, "R2 op 00 ignored");
        run_frame(32, 2'b00, 2'b01, MY_PHY, 5'd0, 16'h0F0F, 1'b0, g, t, dr);
        do_read(5'd0, 16'h00AA, "R2 bad start ignored");
        do_write(5'd7, 16'hBEEF);
        do_read(5'd7, 16'h0000, "R5 unmapped write dropped");

        // Other device address
        run_frame(32, 2'b01, 2'b01, OTHER, 5'd0, 16'h0F0F, 1'b0, g, t, dr);
        do_read(5'd0, 16'h00AA, "R3 foreign write ignored");
        run_frame(32, 2'b01, 2'b10, OTHER, 5'd0, 16'h0, 1'b1, g, t, dr);
        check("R3 foreign read never driven", {15'h0, dr}, 16'h0);
        check("R3 foreign read line high", g, 16'hFFFF);

        // Latch-high events
        evt_pulse(4'b0001);
        do_read(5'd2, 16'h0001, "R8 link fail latched");
        do_read(5'd2, 16'h0000, "R8 cleared by read");
        @(negedge mdc); status_evt = 4'b0010;
        do_read(5'd2, 16'h0002, "R8 active event read");
        do_read(5'd2, 16'h0002, "R8 active event kept");
        @(negedge mdc); status_evt = 4'b0000;
        do_read(5'd2, 16'h0002, "R8 held after release");
        do_read(5'd2, 16'h0000, "R8 cleared after release");
        evt_pulse(4'b1000);
        run_frame(32, 2'b01, 2'b10, OTHER, 5'd2, 16'h0, 1'b1, g, t, dr);
        do_read(5'd2, 16'h0008, "R3 foreign read clears nothing");
        do_read(5'd2, 16'h0000, "R8 duplex cleared");

        // Latch-low link
        @(negedge mdc); link_ok = 1'b0;
        @(negedge mdc); link_ok = 1'b1;
        do_read(5'd1, 16'h0000, "R9 link drop latched");
        do_read(5'd1, 16'h0004, "R9 link restored");

        // Mask and idle interrupt pulse
        do_write(5'd3, 16'h000E);
        do_write(5'd4, 16'h0001);
        do_read(5'd3, 16'h000E, "R10 mask readback");
        pulse_cnt = 0;
        evt_pulse(4'b0100);
        repeat (10) @(negedge mdc);
        check("R10 masked source no pulse", 16'(pulse_cnt), 16'd0);
        evt_pulse(4'b0001);
        repeat (10) @(negedge mdc);
        check("R11 unmasked source one pulse", 16'(pulse_cnt), 16'd1);
        repeat (20) @(negedge mdc);
        check("R11 no repeat pulse", 16'(pulse_cnt), 16'd1);
        do_read(5'd2, 16'h0005, "R8 events after pulse");
        do_write(5'd4, 16'h0000);
        evt_pulse(4'b0001);
        repeat (10) @(negedge mdc);
        check("R11 disabled no pulse", 16'(pulse_cnt), 16'd1);
        do_read(5'd2, 16'h0001, "R8 event while disabled");

        // Self-clearing soft reset
        do_write(5'd4, 16'h0001);
        do_write(5'd3, 16'h0000);
        srst_hi = 0;
        do_write(5'd0, 16'h8011);
        check("R6 soft_reset one cycle", 16'(srst_hi), 16'd1);
        do_read(5'd0, 16'h0000, "R6 ctrl restored");
        do_read(5'd3, 16'h000F, "R6 mask restored");
        do_read(5'd4, 16'h0000, "R6 cfg restored");

        repeat (4) @(negedge mdc);
        summary();
    end

endmodule